// File: doc/BRIEF.md
# NAND Command Register and Status Model

This block is a synthesizable stand-in for the device side of a NAND flash. It decodes command and address bytes that a controller writes, and it keeps a status byte and a ready/busy line for block erase and device reset. Erase and reset take a fixed number of clock cycles, set by parameters. The block has no memory array, no data path and no cell timing. It is meant as the target of a self-checking controller test.

Each write arrives as a single-cycle strobe. `cmd_we` marks a command byte on `bus_i` and `addr_we` marks an address byte. A block erase is 60h, then `ADDR_BYTES` address bytes, then D0h. For a dual-plane erase the controller sends a second 60h and another `ADDR_BYTES` address bytes before D0h. The block runs one busy period for both blocks and has no gap between the two address groups.

Command 70h selects the status byte onto `data_o`. FFh resets the device and cancels any erase in progress. The `force_fail` input lets a bench make an erase report failure on purpose, so that the controller's error handling can be tested.

Top module: `nand_cmd_status_model`

## Requirements
- R1: After `rst_n` is released, `rb_n` is 1 and `data_o` is 00h. A following 70h makes `data_o` read E0h when `wp_n` is 1. The status layout is: bit 7 = `wp_n`, bits 6 and 5 = ready (1) or busy (0), bit 0 = fail, bits 4..1 = 0.
- R2: The sequence 60h, `ADDR_BYTES` address writes, D0h drives `rb_n` low for exactly `ERASE_CYCLES` cycles, starting in the cycle after D0h is latched. A successful erase then reads E0h.
- R3: The sequence 60h, addresses, 60h, addresses, D0h gives exactly one busy period of `ERASE_CYCLES` cycles. `rb_n` stays high until D0h.
- R4: D0h does not start an erase unless it follows a complete address group. This covers D0h with no 60h before it and D0h after too few address bytes. In both cases `rb_n` stays 1.
- R5: While an erase is busy, only 70h and FFh are decoded. Any other command or address write leaves the busy length, the status selection and the sequence state unchanged.
- R6: FFh drives `rb_n` low for exactly `RESET_CYCLES` cycles. If an erase is running, FFh cancels it, and busy ends `RESET_CYCLES` cycles after FFh.
- R7: If FFh cancels an erase, a status read before the reset finishes shows bit 0 = 1 (81h with `wp_n` high). Once the reset finishes, the fail bit is 0 (E0h).
- R8: An FFh received while a reset is still in progress is ignored and does not lengthen the busy period.
- R9: With `wp_n` low, status bit 7 reads 0. A D0h confirm is then rejected: `rb_n` stays high and the fail bit is set (61h).
- R10: The level of `force_fail` when D0h is latched decides the erase result. If it is 1, the status after the erase is E1h. The next erase started with `force_fail` at 0 reads E0h.
- R11: `data_o` shows the status byte only after 70h. It reads 00h after any other command that is decoded, including FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle |
| addr_we | input | 1 | Address write strobe, one cycle |
| bus_i | input | 8 | Command or address byte |
| wp_n | input | 1 | Write protect, active low |
| force_fail | input | 1 | Makes the erase confirmed in this cycle report failure |
| rb_n | output | 1 | Ready (1) / busy (0) |
| data_o | output | 8 | Status byte when selected by 70h, otherwise 00h |

## Verification
The hardest state to reach from the ports is the fail flag left by a cancelled erase. It is visible only between the FFh and the end of the reset busy period. The bench starts an erase, waits a few cycles, issues FFh and then 70h in the next two cycles, and reads 81h. It then measures the remaining busy length, which must be `RESET_CYCLES` minus the one cycle used by the status command. For commands ignored during busy periods, the bench counts how many cycles its own writes used and checks that the remaining busy time matches the parameter exactly.

// File: rtl/nand_cmd_status_model.sv
module nand_cmd_status_model #(
  parameter int ERASE_CYCLES = 60,
  parameter int RESET_CYCLES = 12,
  parameter int ADDR_BYTES   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       addr_we,
  input  logic [7:0] bus_i,
  input  logic       wp_n,
  input  logic       force_fail,
  output logic       rb_n,
  output logic [7:0] data_o
);
  localparam int MAXC = (ERASE_CYCLES > RESET_CYCLES) ? ERASE_CYCLES : RESET_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int AW   = $clog2(ADDR_BYTES + 1);
  localparam logic [7:0] OP_SETUP  = 8'h60;
  localparam logic [7:0] OP_GO     = 8'hD0;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  typedef enum logic [2:0] {SQ_IDLE, SQ_ADR1, SQ_NEXT, SQ_ADR2, SQ_CONF} seq_t;

  seq_t          seq;
  logic [CW-1:0] busy_cnt;
  logic [AW-1:0] acnt;
  logic          in_reset, fail, fail_arm, stat_sel;

  assign rb_n   = (busy_cnt == '0);
  assign data_o = stat_sel ? {wp_n, rb_n, rb_n, 4'b0000, fail} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq      <= SQ_IDLE;
      busy_cnt <= '0;
      acnt     <= '0;
      in_reset <= 1'b0;
      fail     <= 1'b0;
      fail_arm <= 1'b0;
      stat_sel <= 1'b0;
    end else begin
      if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CW'(1)) begin
          fail     <= in_reset ? 1'b0 : fail_arm;
          in_reset <= 1'b0;
        end
      end
      if (cmd_we) begin
        if (bus_i == OP_RESET) begin
          if (!in_reset) begin
            in_reset <= 1'b1;
            busy_cnt <= CW'(RESET_CYCLES);
            fail     <= (busy_cnt != '0);
            seq      <= SQ_IDLE;
            stat_sel <= 1'b0;
          end
        end else if (bus_i == OP_STATUS) begin
          stat_sel <= 1'b1;
        end else if (busy_cnt == '0) begin
          stat_sel <= 1'b0;
          case (bus_i)
            OP_SETUP: begin
              seq  <= (seq == SQ_NEXT) ? SQ_ADR2 : SQ_ADR1;
              acnt <= '0;
            end
            OP_GO: begin
              seq <= SQ_IDLE;
              if (seq == SQ_NEXT || seq == SQ_CONF) begin
                if (!wp_n) begin
                  fail <= 1'b1;
                end else begin
                  busy_cnt <= CW'(ERASE_CYCLES);
                  fail     <= 1'b0;
                  fail_arm <= force_fail;
                end
              end
            end
            default: seq <= SQ_IDLE;
          endcase
        end
      end else if (addr_we && busy_cnt == '0 && (seq == SQ_ADR1 || seq == SQ_ADR2)) begin
        acnt <= acnt + 1'b1;
        if (acnt == AW'(ADDR_BYTES - 1))
          seq <= (seq == SQ_ADR1) ? SQ_NEXT : SQ_CONF;
      end
    end
  end
endmodule

module nand_cmd_status_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    bus_i,
  input logic          wp_n,
  input logic          rb_n,
  input logic [7:0]    data_o,
  input logic [CW-1:0] busy_cnt,
  input logic          in_reset,
  input logic          fail
);
  // R8
  rst_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && busy_cnt > CW'(1) && cmd_we && bus_i == 8'hFF) |=> (busy_cnt == $past(busy_cnt) - 1'b1));
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_reset && busy_cnt > CW'(1) && cmd_we && bus_i != 8'h70 && bus_i != 8'hFF)
    |=> (busy_cnt == $past(busy_cnt) - 1'b1));
  // R9
  wp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_n && !wp_n && cmd_we && bus_i == 8'hD0) |=> rb_n);
  // R9
  wp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) !wp_n |-> !data_o[7]);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(rb_n) |-> $past(cmd_we));
  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_n) && $past(in_reset)) |-> !fail);
endmodule

bind nand_cmd_status_model nand_cmd_status_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .bus_i(bus_i), .wp_n(wp_n),
  .rb_n(rb_n), .data_o(data_o), .busy_cnt(busy_cnt), .in_reset(in_reset), .fail(fail)
);

// File: tb/nand_cmd_status_model_tb.sv
module nand_cmd_status_model_tb_top;
  localparam int ER = 60;
  localparam int RS = 12;
  localparam int AB = 3;

  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0, addr_we = 1'b0;
  logic wp_n = 1'b1, force_fail = 1'b0;
  logic [7:0] bus_i = 8'h00;
  logic rb_n;
  logic [7:0] data_o;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nand_cmd_status_model #(.ERASE_CYCLES(ER), .RESET_CYCLES(RS), .ADDR_BYTES(AB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we), .bus_i(bus_i),
    .wp_n(wp_n), .force_fail(force_fail), .rb_n(rb_n), .data_o(data_o));

  task automatic chk(input int act, input int exp, input string tag);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_we = 1'b1; bus_i = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic adr(input logic [7:0] b);
    addr_we = 1'b1; bus_i = b;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic adr_group();
    for (int i = 0; i < AB; i++) adr(8'(i + 5));
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!rb_n && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    chk(rb_n, 1, "R1 rb_n after reset");
    chk(data_o, 8'h00, "R1 data_o unselected");
    cmd(8'h70);
    chk(data_o, 8'hE0, "R1 status after reset");
  endtask

  task automatic t_single_erase();
    int n;
    cmd(8'h60); adr_group();
    chk(rb_n, 1, "R2 ready before confirm");
    cmd(8'hD0);
    busy_len(n);
    chk(n, ER, "R2 erase busy length");
    cmd(8'h70);
    chk(data_o, 8'hE0, "R2 status after erase");
  endtask

  task automatic t_dual_erase();
    int n;
    cmd(8'h60); adr_group();
    cmd(8'h60);
    chk(rb_n, 1, "R3 no busy between planes");
    adr_group();
    cmd(8'hD0);
    busy_len(n);
    chk(n, ER, "R3 dual erase busy length");
  endtask

  task automatic t_incomplete();
    cmd(8'hD0);
    chk(rb_n, 1, "R4 bare confirm ignored");
    cmd(8'h60); adr(8'h01); adr(8'h02);
    cmd(8'hD0);
    chk(rb_n, 1, "R4 short address ignored");
    @(negedge clk);
    chk(rb_n, 1, "R4 still ready");
  endtask

  task automatic t_busy_ignore();
    int n;
    cmd(8'h60); adr_group(); cmd(8'hD0);
    cmd(8'h70);
    chk(data_o, 8'h80, "R5 status while erasing");
    cmd(8'h60); adr(8'h00); cmd(8'h90); cmd(8'hD0);
    chk(data_o, 8'h80, "R5 selection kept while busy");
    busy_len(n);
    chk(n, ER - 5, "R5 busy length unchanged");
    cmd(8'hD0);
    chk(rb_n, 1, "R5 ignored setup left no sequence");
  endtask

  task automatic t_abort();
    int n;
    cmd(8'h60); adr_group(); cmd(8'hD0);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    chk(data_o, 8'h00, "R11 reset deselects status");
    cmd(8'h70);
    chk(data_o, 8'h81, "R7 aborted fail during reset");
    busy_len(n);
    chk(n, RS - 1, "R6 reset busy replaces erase");
    chk(data_o, 8'hE0, "R7 fail cleared after reset");
  endtask

  task automatic t_reset_repeat();
    int n;
    cmd(8'hFF);
    cmd(8'hFF);
    busy_len(n);
    chk(n, RS - 1, "R8 repeated reset ignored");
    cmd(8'hFF);
    busy_len(n);
    chk(n, RS, "R6 reset busy length");
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    cmd(8'h70);
    chk(data_o, 8'h60, "R9 protect bit low");
    cmd(8'h60); adr_group(); cmd(8'hD0);
    chk(rb_n, 1, "R9 confirm rejected");
    cmd(8'h70);
    chk(data_o, 8'h61, "R9 fail set on reject");
    wp_n = 1'b1;
    @(negedge clk);
    chk(data_o, 8'hE1, "R9 protect released");
  endtask

  task automatic t_force();
    int n;
    cmd(8'h60); adr_group();
    force_fail = 1'b1;
    cmd(8'hD0);
    force_fail = 1'b0;
    busy_len(n);
    cmd(8'h70);
    chk(data_o, 8'hE1, "R10 forced fail");
    cmd(8'h60); adr_group(); cmd(8'hD0);
    busy_len(n);
    cmd(8'h70);
    chk(data_o, 8'hE0, "R10 next erase passes");
    cmd(8'h90);
    chk(data_o, 8'h00, "R11 other command deselects");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_erase();
    t_dual_erase();
    t_incomplete();
    t_busy_ignore();
    t_abort();
    t_reset_repeat();
    t_wp();
    cmd(8'hFF);
    repeat (RS + 2) @(negedge clk);
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      applied++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule